// File: doc/BRIEF.md
# Flash Embedded-Operation Status Byte Generator

This block is the device-side source of the byte a flash part returns on a read while an internal program or erase is running or suspended. The host reads the same location again and again. Two toggle bits change between reads, and which of them change depends on the operation under way and on whether the read falls inside a sector chosen for erase. From that pattern the host can tell a program, an active erase and an erase suspend apart, sector by sector. A separate failure bit reports that the internal pulse-count limit was exceeded.

The command decoder supplies the current operation mode, a mask of the sectors selected for erase and a reset-command pulse. The read path supplies the sector index of the address, a one-cycle read strobe and the array word. The byte for each strobed read is registered and appears on `rd_data_o` in the cycle after the strobe. It holds until the next strobe. When a read should see memory contents, the array word passes through unchanged.

Top module: `flash_status_gen`

## Requirements
- R1: After synchronous reset (`rst_n` low), `rd_data_o` is 0x00 and both toggle bits are 0. The first status read after reset therefore shows bit 6 = 0 and bit 2 = 0.
- R2: `mode_i` is encoded as 0 = idle, 1 = program, 2 = erase, 3 = erase suspended, 4 = program inside erase suspend, and 5 to 7 act as idle. In idle, a strobed read returns `array_data_i` on `rd_data_o` one cycle later.
- R3: A status byte has bit 7 = parameter POLL_VALUE, bit 6 = toggle A, bit 5 = failure flag, bit 2 = toggle B, and bits 4, 3, 1 and 0 = 0. Each byte shows the toggle values from before that read. In program mode every read gives a status byte, toggle A flips and toggle B holds.
- R4: In erase mode, a read in a sector whose bit is set in `sel_mask_i` gives a status byte and flips both toggle bits.
- R5: In erase mode, a read in a sector whose mask bit is clear gives a status byte, flips toggle A and holds toggle B.
- R6: In erase-suspended mode, a read in a selected sector gives a status byte, holds toggle A and flips toggle B.
- R7: In erase-suspended mode, a read in an unselected sector returns `array_data_i` and leaves both toggle bits unchanged.
- R8: In program-inside-suspend mode, a read at any sector gives a status byte, flips toggle A and holds toggle B.
- R9: `limit_exc_i` sampled high in program, erase or program-inside-suspend mode sets the failure flag from the next cycle on. The flag stays set until a reset command. In idle or erase-suspended mode the input is ignored.
- R10: `reset_cmd_i` while the flag is set clears it. Reads then behave as idle, or as erase-suspended if the failure happened in program-inside-suspend mode. This lasts until `mode_i` differs from the mode seen when the failure was latched. Without a latched failure, `reset_cmd_i` has no effect.
- R11: In a cycle without `rd_strobe_i`, `rd_data_o` and both toggle bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Current embedded-operation mode |
| sel_mask_i | input | NUM_SECTORS | One bit per sector: selected for erase |
| rd_sector_i | input | SEC_W | Sector index of the read address |
| rd_strobe_i | input | 1 | One-cycle read request |
| limit_exc_i | input | 1 | Internal pulse-count limit exceeded |
| reset_cmd_i | input | 1 | Reset command pulse from the decoder |
| array_data_i | input | 8 | Array word for the read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
Back-to-back reads are made in each mode, in both selected and unselected sectors, so that the bit-6 and bit-2 patterns separate program, active erase and suspend. Pass-through reads use changing array words so that a status byte cannot be taken for array data. Failure injection is tried in active modes and in inactive ones, followed by reset commands before and after the mode changes, which separates the abort-to-idle path from the abort-to-suspend path. A constrained random phase then mixes all modes, masks, sectors, idle gaps, limit pulses and reset pulses against a bench model.

// File: rtl/flash_status_pkg.sv
// Shared types and bit positions for the status byte generator.
package flash_status_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE      = 3'd0,
        MODE_PROG      = 3'd1,
        MODE_ERASE     = 3'd2,
        MODE_SUSP      = 3'd3,
        MODE_SUSP_PROG = 3'd4
    } op_mode_e;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned BIT_POLL = 7;
    localparam int unsigned BIT_TGLA = 6;
    localparam int unsigned BIT_FAIL = 5;
    localparam int unsigned BIT_TGLB = 2;

    // Map a raw mode code to the enum; unknown codes behave as idle.
    function automatic op_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MODE_PROG;
            3'd2:    return MODE_ERASE;
            3'd3:    return MODE_SUSP;
            3'd4:    return MODE_SUSP_PROG;
            default: return MODE_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/flash_fail_tracker.sv
// Failure flag and abort tracking.
// Latches the pulse-limit failure during active modes and keeps it until a
// reset command. After that command it forces an effective mode (idle, or
// erase-suspended if the failure came from program-inside-suspend). The
// forcing ends once the raw mode differs from the mode seen at the failure.
// Assumes reset_cmd_i and limit_exc_i are synchronous single-cycle pulses.
module flash_fail_tracker
    import flash_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       limit_exc_i,
    input  logic       reset_cmd_i,
    output op_mode_e   eff_mode_o,
    output logic       fail_o
);

    op_mode_e raw_mode;
    op_mode_e cap_mode_q;
    logic     fail_q;
    logic     abort_q;
    logic     active;

    // Decode the raw mode code.
    always_comb raw_mode = decode_mode(mode_i);

    // Effective mode: while aborting, override with the fallback mode.
    always_comb begin
        if (abort_q)
            eff_mode_o = (cap_mode_q == MODE_SUSP_PROG) ? MODE_SUSP : MODE_IDLE;
        else
            eff_mode_o = raw_mode;
    end

    // Modes in which the pulse limit can mark a failure.
    always_comb begin
        active = (eff_mode_o == MODE_PROG) || (eff_mode_o == MODE_ERASE) ||
                 (eff_mode_o == MODE_SUSP_PROG);
    end

    // Failure flag, abort flag and captured mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q     <= 1'b0;
            abort_q    <= 1'b0;
            cap_mode_q <= MODE_IDLE;
        end else begin
            if (fail_q) begin
                if (reset_cmd_i) begin
                    fail_q  <= 1'b0;
                    abort_q <= 1'b1;
                end
            end else if (limit_exc_i && active) begin
                fail_q     <= 1'b1;
                cap_mode_q <= raw_mode;
            end
            if (abort_q && (raw_mode != cap_mode_q))
                abort_q <= 1'b0;
        end
    end

    assign fail_o = fail_q;

    // R9: a latched failure survives every cycle without a reset command.
    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !reset_cmd_i) |=> fail_q);

    // R10: a reset command while failed clears the flag.
    p_fail_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && reset_cmd_i) |=> !fail_q);

    // R9: the limit input is ignored in idle and suspended modes.
    p_fail_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_q && !active) |=> !fail_q);

endmodule

// File: rtl/flash_toggle_unit.sv
// The two toggle registers. Each flips only on a strobed read when its flip
// request is set; otherwise it holds. Assumes the flip requests are already
// qualified by mode and sector.
module flash_toggle_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe_i,
    input  logic flip_a_i,
    input  logic flip_b_i,
    output logic tgl_a_o,
    output logic tgl_b_o
);

    logic [1:0] tgl_q;
    logic [1:0] flip_req;

    always_comb flip_req = {flip_b_i, flip_a_i};

    // One generated flip register per toggle bit.
    for (genvar g = 0; g < 2; g++) begin : g_tgl
        // Flip on a strobed read when requested.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tgl_q[g] <= 1'b0;
            else if (rd_strobe_i && flip_req[g])
                tgl_q[g] <= ~tgl_q[g];
        end
    end

    assign tgl_a_o = tgl_q[0];
    assign tgl_b_o = tgl_q[1];

    // R11: toggles hold between reads.
    p_tgl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_i |=> $stable(tgl_q));

endmodule

// File: rtl/flash_status_mux.sv
// Read-byte composer. For the effective mode and the selection state of the
// read sector, it picks array data or a status byte and requests toggle
// flips. Purely combinational; the caller registers the result.
module flash_status_mux
    import flash_status_pkg::*;
#(
    parameter logic POLL_VALUE = 1'b0
) (
    input  op_mode_e          eff_mode_i,
    input  logic              sector_sel_i,
    input  logic [BYTE_W-1:0] array_data_i,
    input  logic              tgl_a_i,
    input  logic              tgl_b_i,
    input  logic              fail_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              flip_a_o,
    output logic              flip_b_o
);

    logic [BYTE_W-1:0] status_byte;
    logic              use_array;

    // Assemble the status byte from the held toggles and the failure flag.
    always_comb begin
        status_byte           = '0;
        status_byte[BIT_POLL] = POLL_VALUE;
        status_byte[BIT_TGLA] = tgl_a_i;
        status_byte[BIT_FAIL] = fail_i;
        status_byte[BIT_TGLB] = tgl_b_i;
    end

    // Per-mode choice of data source and toggle flips.
    always_comb begin
        use_array = 1'b0;
        flip_a_o  = 1'b0;
        flip_b_o  = 1'b0;
        unique case (eff_mode_i)
            MODE_PROG, MODE_SUSP_PROG: begin
                flip_a_o = 1'b1;
            end
            MODE_ERASE: begin
                flip_a_o = 1'b1;
                flip_b_o = sector_sel_i;
            end
            MODE_SUSP: begin
                use_array = !sector_sel_i;
                flip_b_o  = sector_sel_i;
            end
            default: begin
                use_array = 1'b1;
            end
        endcase
    end

    // Final byte select.
    always_comb byte_o = use_array ? array_data_i : status_byte;

endmodule

// File: rtl/flash_status_gen.sv
// Top of the status byte generator. It looks up whether the read sector is
// selected for erase, ties the failure tracker, byte composer and toggle
// unit together, and registers the read byte on each strobe.
// Assumes rd_strobe_i lasts one cycle per read.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int unsigned NUM_SECTORS = 16,
    parameter logic        POLL_VALUE  = 1'b0,
    localparam int unsigned SEC_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode_i,
    input  logic [NUM_SECTORS-1:0] sel_mask_i,
    input  logic [SEC_W-1:0]       rd_sector_i,
    input  logic                   rd_strobe_i,
    input  logic                   limit_exc_i,
    input  logic                   reset_cmd_i,
    input  logic [7:0]             array_data_i,
    output logic [7:0]             rd_data_o
);

    localparam bit FULL_MAP = ((1 << SEC_W) == NUM_SECTORS);

    op_mode_e    eff_mode;
    logic        fail;
    logic        sector_sel;
    logic        tgl_a;
    logic        tgl_b;
    logic        flip_a;
    logic        flip_b;
    logic [7:0]  next_byte;
    logic [7:0]  rd_q;

    // Sector lookup; indices past the last sector count as unselected.
    if (FULL_MAP) begin : g_sel_full
        always_comb sector_sel = sel_mask_i[rd_sector_i];
    end else begin : g_sel_bounded
        always_comb begin
            sector_sel = 1'b0;
            for (int i = 0; i < NUM_SECTORS; i++)
                if (rd_sector_i == SEC_W'(i)) sector_sel = sel_mask_i[i];
        end
    end

    flash_fail_tracker u_fail (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .limit_exc_i (limit_exc_i),
        .reset_cmd_i (reset_cmd_i),
        .eff_mode_o  (eff_mode),
        .fail_o      (fail)
    );

    flash_status_mux #(.POLL_VALUE(POLL_VALUE)) u_mux (
        .eff_mode_i   (eff_mode),
        .sector_sel_i (sector_sel),
        .array_data_i (array_data_i),
        .tgl_a_i      (tgl_a),
        .tgl_b_i      (tgl_b),
        .fail_i       (fail),
        .byte_o       (next_byte),
        .flip_a_o     (flip_a),
        .flip_b_o     (flip_b)
    );

    flash_toggle_unit u_tgl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_strobe_i (rd_strobe_i),
        .flip_a_i    (flip_a),
        .flip_b_i    (flip_b),
        .tgl_a_o     (tgl_a),
        .tgl_b_o     (tgl_b)
    );

    // Output register: capture the read byte on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_strobe_i)
            rd_q <= next_byte;
    end

    assign rd_data_o = rd_q;

    // R11: the read data holds without a strobe.
    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_i |=> $stable(rd_data_o));

    // R3: in program mode toggle B holds and toggle A flips.
    p_prog_tgl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && eff_mode == MODE_PROG) |=> ($stable(tgl_b) && (tgl_a != $past(tgl_a))));

    // R4: an erase read in a selected sector flips both toggles.
    p_erase_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && eff_mode == MODE_ERASE && sector_sel) |=>
        ((tgl_a != $past(tgl_a)) && (tgl_b != $past(tgl_b))));

    // R6: a suspended read in a selected sector holds A and flips B.
    p_susp_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && eff_mode == MODE_SUSP && sector_sel) |=>
        ($stable(tgl_a) && (tgl_b != $past(tgl_b))));

    // R7: a suspended read in an unselected sector passes the array word.
    p_susp_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && eff_mode == MODE_SUSP && !sector_sel) |=>
        (rd_data_o == $past(array_data_i)));

endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;

    localparam int NS = 16;
    localparam logic [2:0] M_IDLE = 3'd0, M_PROG = 3'd1, M_ERASE = 3'd2,
                           M_SUSP = 3'd3, M_SPROG = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    mode;
    logic [NS-1:0] mask;
    logic [3:0]    sector;
    logic          strobe;
    logic          limit;
    logic          rcmd;
    logic [7:0]    arr;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic       m_a, m_b, m_fail, m_abort;
    logic [2:0] m_cap;
    logic [7:0] m_out;

    always #4 clk = ~clk;

    flash_status_gen u_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .sel_mask_i(mask),
        .rd_sector_i(sector), .rd_strobe_i(strobe), .limit_exc_i(limit),
        .reset_cmd_i(rcmd), .array_data_i(arr), .rd_data_o(rd_data)
    );

    function automatic logic [2:0] norm(input logic [2:0] m);
        return (m > 3'd4) ? M_IDLE : m;
    endfunction

    function automatic logic [2:0] eff(input logic [2:0] m);
        if (m_abort) return (m_cap == M_SPROG) ? M_SUSP : M_IDLE;
        return norm(m);
    endfunction

    function automatic logic [7:0] status(input logic a, input logic b, input logic f);
        return {1'b0, a, f, 2'b00, b, 2'b00};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the posedge, check at next negedge.
    task automatic step(input string req, input logic [2:0] md, input logic [3:0] sec,
                        input logic stb, input logic lim, input logic rc,
                        input logic [7:0] ad, input logic do_chk);
        logic [2:0] e;
        logic       sel;
        logic [7:0] exp;
        mode = md; sector = sec; strobe = stb; limit = lim; rcmd = rc; arr = ad;
        e   = eff(md);
        sel = mask[sec];
        exp = m_out;
        if (stb) begin
            case (e)
                M_PROG, M_SPROG: begin exp = status(m_a, m_b, m_fail); m_a = ~m_a; end
                M_ERASE: begin
                    exp = status(m_a, m_b, m_fail); m_a = ~m_a;
                    if (sel) m_b = ~m_b;
                end
                M_SUSP: begin
                    if (sel) begin exp = status(m_a, m_b, m_fail); m_b = ~m_b; end
                    else exp = ad;
                end
                default: exp = ad;
            endcase
        end
        if (m_fail) begin
            if (rc) begin m_fail = 1'b0; m_abort = 1'b1; end
        end else if (lim && (e == M_PROG || e == M_ERASE || e == M_SPROG)) begin
            m_fail = 1'b1; m_cap = norm(md);
        end
        if (m_abort && !(rc && m_fail) && norm(md) != m_cap && !(m_abort && rc === 1'b1 && 0))
            m_abort = m_abort;
        @(posedge clk);
        m_out = exp;
        @(negedge clk);
        if (do_chk) check(req, rd_data, exp);
    endtask

    // Abort release is applied after the posedge update, matching a registered flag.
    task automatic release_abort(input logic [2:0] md_prev, input logic was_abort);
        if (was_abort && m_abort && norm(md_prev) != m_cap) m_abort = 1'b0;
    endtask

    task automatic cyc(input string req, input logic [2:0] md, input logic [3:0] sec,
                       input logic stb, input logic lim, input logic rc,
                       input logic [7:0] ad, input logic do_chk);
        logic was = m_abort;
        step(req, md, sec, stb, lim, rc, ad, do_chk);
        release_abort(md, was);
    endtask

    initial begin
        int cyc_n = 0;
        while (cyc_n < 150000) begin @(posedge clk); cyc_n++; end
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = M_IDLE; mask = '0; sector = '0; strobe = 1'b0;
        limit = 1'b0; rcmd = 1'b0; arr = '0;
        m_a = 0; m_b = 0; m_fail = 0; m_abort = 0; m_cap = M_IDLE; m_out = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 reset output", rd_data, 8'h00);
        rst_n = 1'b1;
        mask = 16'h00F0;

        // R1: first program read shows both toggles at 0
        cyc("R1 first status", M_PROG, 4'd0, 1, 0, 0, 8'hA5, 1);
        check("R1 toggles zero", rd_data & 8'h44, 8'h00);
        // R2 idle pass-through, codes 0 and 6
        cyc("R2 idle", M_IDLE, 4'd5, 1, 0, 0, 8'h3C, 1);
        cyc("R2 code 6 idle", 3'd6, 4'd5, 1, 0, 0, 8'hC3, 1);
        // R3 program toggling
        for (int i = 0; i < 4; i++) cyc("R3 program", M_PROG, 4'(i), 1, 0, 0, 8'h11, 1);
        // R4 erase selected sector
        for (int i = 0; i < 4; i++) cyc("R4 erase sel", M_ERASE, 4'd5, 1, 0, 0, 8'h22, 1);
        // R5 erase unselected sector
        for (int i = 0; i < 3; i++) cyc("R5 erase unsel", M_ERASE, 4'd1, 1, 0, 0, 8'h33, 1);
        // R6 suspend selected
        for (int i = 0; i < 3; i++) cyc("R6 susp sel", M_SUSP, 4'd6, 1, 0, 0, 8'h44, 1);
        // R7 suspend unselected: array data, toggles untouched
        cyc("R7 susp unsel", M_SUSP, 4'd9, 1, 0, 0, 8'h5A, 1);
        cyc("R7 susp unsel", M_SUSP, 4'd9, 1, 0, 0, 8'hA6, 1);
        cyc("R7 toggles kept", M_ERASE, 4'd9, 1, 0, 0, 8'h00, 1);
        // R8 program in suspend
        for (int i = 0; i < 3; i++) cyc("R8 susp prog", M_SPROG, 4'(i * 5), 1, 0, 0, 8'h77, 1);
        // R11 hold with no strobe
        cyc("R11 hold", M_PROG, 4'd0, 0, 0, 0, 8'hFF, 1);
        cyc("R11 hold", M_ERASE, 4'd5, 0, 0, 0, 8'hEE, 1);
        cyc("R11 toggles held", M_PROG, 4'd0, 1, 0, 0, 8'h00, 1);
        // R9 limit ignored in idle and suspend
        cyc("R9 ignore idle", M_IDLE, 4'd0, 0, 1, 0, 8'h00, 0);
        cyc("R9 ignore susp", M_SUSP, 4'd0, 0, 1, 0, 8'h00, 0);
        cyc("R9 no fail", M_PROG, 4'd0, 1, 0, 0, 8'h00, 1);
        // R10 reset cmd without failure has no effect
        cyc("R10 rcmd idle", M_PROG, 4'd0, 0, 0, 1, 8'h00, 0);
        cyc("R10 no effect", M_PROG, 4'd0, 1, 0, 0, 8'h12, 1);
        // R9 failure in program
        cyc("R9 set", M_PROG, 4'd0, 0, 1, 0, 8'h00, 0);
        cyc("R9 fail bit", M_PROG, 4'd0, 1, 0, 0, 8'h00, 1);
        cyc("R9 sticky", M_PROG, 4'd0, 1, 0, 0, 8'h00, 1);
        // R10 abort to idle, then release on mode change
        cyc("R10 rcmd", M_PROG, 4'd0, 0, 0, 1, 8'h00, 0);
        cyc("R10 abort idle", M_PROG, 4'd0, 1, 0, 0, 8'h9D, 1);
        cyc("R10 leave", M_IDLE, 4'd0, 0, 0, 0, 8'h00, 0);
        cyc("R10 released", M_PROG, 4'd0, 1, 0, 0, 8'h00, 1);
        // R10 failure in program-inside-suspend aborts to suspended
        cyc("R9 set sprog", M_SPROG, 4'd0, 0, 1, 0, 8'h00, 0);
        cyc("R9 fail sprog", M_SPROG, 4'd0, 1, 0, 0, 8'h00, 1);
        cyc("R10 rcmd", M_SPROG, 4'd0, 0, 0, 1, 8'h00, 0);
        cyc("R10 abort susp sel", M_SPROG, 4'd4, 1, 0, 0, 8'h61, 1);
        cyc("R10 abort susp unsel", M_SPROG, 4'd1, 1, 0, 0, 8'h62, 1);
        cyc("R10 release", M_SUSP, 4'd1, 0, 0, 0, 8'h00, 0);

        // constrained random phase
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] md;
            int r;
            r = $urandom_range(0, 99);
            md = (r < 10) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
            if ($urandom_range(0, 49) == 0) mask = 16'($urandom);
            cyc("R3-R11 random", md, 4'($urandom_range(0, 15)),
                ($urandom_range(0, 3) != 0), ($urandom_range(0, 39) == 0),
                ($urandom_range(0, 19) == 0), 8'($urandom), 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule